// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an on-chip host port and an external asynchronous static RAM of 64K words by 16 bits. The host presents one request at a time over a valid/ready handshake, carrying an address, write data, a write flag and a two-bit byte mask. The controller turns each request into a pin-level cycle on the RAM: registered address, active-low chip select, write strobe, output enable and one enable per byte lane. It also drives the data bus through a separate output value and output-enable pair, which the pad ring turns into a tri-state pin.

Every timing minimum of the RAM is given in picoseconds as a parameter and converted to whole clock cycles by rounding up. After reset the controller refuses requests until a power-up wait has expired. Between transfers it keeps chip select high so that the RAM stays in standby. Write data is driven from the cycle the write strobe falls until one cycle after it rises, so hold time is always positive. The bus is never driven while output enable is low or in the cycle after it was low. Read data is captured on the last cycle of the read phase and returned with a one-cycle valid pulse. A request whose byte mask is all zero finishes at once without touching the RAM.

Top module: `sram_byte_ctl`

## Requirements
- R1: After reset, req_ready stays low for exactly PWRUP_CYC = ceil(T_PWRUP_PS / CLK_PS) clock cycles (10000 at the defaults), and mem_ce_n stays high during that wait even while req_valid is held high.
- R2: While no transfer is in progress, including during reset, mem_ce_n, mem_we_n, mem_oe_n and every bit of mem_be_n are high and mem_dq_oe is low.
- R3: In the cycle after a write with a nonzero mask is accepted, mem_ce_n and mem_we_n are low and mem_be_n equals the inverted mask (mask bit 0 / mem_be_n[0] covers data bits 7:0, mask bit 1 / mem_be_n[1] covers bits 15:8). mem_we_n stays low for WR_CYC cycles and rises one cycle before mem_ce_n and mem_be_n rise.
- R4: During a write, mem_dq_oe is high and mem_dq_out and mem_addr hold the request's data and address. This lasts from the cycle mem_we_n falls through the cycle after it rises, and mem_addr is stable for as long as mem_ce_n is low.
- R5: In the cycle after a read with a nonzero mask is accepted, mem_ce_n and mem_oe_n are low, mem_we_n is high and mem_be_n equals the inverted mask. This lasts RD_CYC cycles. rd_valid then pulses for one cycle, RD_CYC cycles after that first strobe cycle, while mem_ce_n is high. rd_data carries the RAM's lanes for mask bits that are 1 and zero for the other lanes.
- R6: mem_dq_oe is never high while mem_oe_n is low, nor in the cycle after a cycle in which mem_oe_n was low.
- R7: A request with an all-zero mask is accepted without any cycle of mem_ce_n low. A zero-mask write changes no stored word. A zero-mask read gives rd_valid with rd_data = 0 in the cycle right after acceptance.
- R8: A request is accepted only on a clock edge where req_valid and req_ready are both high. req_ready is low in every cycle in which mem_ce_n is low.
- R9: RD_CYC = max(ceil(T_AA), ceil(T_DOE), ceil(T_RC), 1) and WR_CYC = max(ceil(T_PWE), ceil(T_SD), ceil(T_WC) - 1, 1), in clock cycles. Both are 1 at the defaults.
- R10: A read of a word returns, in each lane, the data of the most recent write that enabled that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte-lane enables, active low, bit 0 = lower lane |
| mem_dq_out | output | 16 | Data value driven toward the RAM |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 16 | Data sampled from the RAM pins |

## Verification
A wrong state register or phase count shows up on the strobe pins in the first cycle of the faulty transfer. A write strobe that is too short, too long, or not followed by the hold cycle is caught at the edge where mem_we_n rises. A lane-mask or capture error appears in rd_data as garbage or stale bytes at the single rd_valid pulse of the affected read. Lost or misdirected writes appear later, when the sweep reads the word back. A bus conflict shows as mem_dq_oe high next to a low mem_oe_n within one cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_WREC = 2'd3
   } ctl_state_e;

   // Round a time in picoseconds up to whole clock cycles.
   function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Cycles of the output-enable phase of a read.
   function automatic int rd_cycles(input int t_aa, input int t_doe,
                                    input int t_rc, input int clk_ps);
      return imax(imax(ps_to_cyc(t_aa, clk_ps), ps_to_cyc(t_doe, clk_ps)),
                  imax(ps_to_cyc(t_rc, clk_ps), 1));
   endfunction

   // Cycles of the write strobe; one hold cycle always follows it.
   function automatic int wr_cycles(input int t_pwe, input int t_sd,
                                    input int t_wc, input int clk_ps);
      return imax(imax(ps_to_cyc(t_pwe, clk_ps), ps_to_cyc(t_sd, clk_ps)),
                  imax(ps_to_cyc(t_wc, clk_ps) - 1, 1));
   endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
   parameter int CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int W = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("sram_pwrup_wait: CYC must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == W'(CYC - 1)) begin
            done_q <= 1'b1;
         end
      end
   end

   assign done = done_q;

endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
   parameter int MAXV = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [((MAXV < 1) ? 1 : $clog2(MAXV + 1))-1:0] load_val,
   output logic                last
);
   localparam int W = (MAXV < 1) ? 1 : $clog2(MAXV + 1);

   if (MAXV < 0) begin : g_bad_max
      $error("sram_phase_cnt: MAXV must not be negative");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
   parameter int LANES  = 2,
   parameter int DATA_W = 16
) (
   input  logic [LANES-1:0]  req_mask,
   input  logic [LANES-1:0]  held_mask,
   input  logic [DATA_W-1:0] dq_in,
   output logic [LANES-1:0]  be_n,
   output logic [DATA_W-1:0] rd_masked
);
   localparam int LANE_W = DATA_W / LANES;

   if (LANE_W * LANES != DATA_W) begin : g_bad_split
      $error("sram_lane_map: DATA_W must split evenly into LANES");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign be_n[l] = ~req_mask[l];
      assign rd_masked[l*LANE_W +: LANE_W] =
         held_mask[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int LANES      = DATA_W / 8,
   parameter int CLK_PS     = 10000,
   parameter int T_PWRUP_PS = 100_000_000,
   parameter int T_RC_PS    = 10000,
   parameter int T_AA_PS    = 10000,
   parameter int T_DOE_PS   = 5000,
   parameter int T_WC_PS    = 10000,
   parameter int T_PWE_PS   = 7000,
   parameter int T_SD_PS    = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int PWRUP_CYC = ps_to_cyc(T_PWRUP_PS, CLK_PS);
   localparam int RD_CYC    = rd_cycles(T_AA_PS, T_DOE_PS, T_RC_PS, CLK_PS);
   localparam int WR_CYC    = wr_cycles(T_PWE_PS, T_SD_PS, T_WC_PS, CLK_PS);
   localparam int PH_MAX    = imax(RD_CYC, WR_CYC) - 1;
   localparam int PH_W      = (PH_MAX < 1) ? 1 : $clog2(PH_MAX + 1);

   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("sram_byte_ctl: DATA_W must be a multiple of 8");
   end
   if (LANES * 8 != DATA_W) begin : g_bad_lanes
      $error("sram_byte_ctl: LANES must equal DATA_W / 8");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_byte_ctl: CLK_PS must be positive");
   end

   ctl_state_e        state_q;
   logic              pwr_ok;
   logic              accept;
   logic              ph_load;
   logic [PH_W-1:0]   ph_val;
   logic              ph_last;
   logic [LANES-1:0]  mask_q;
   logic [LANES-1:0]  req_be_n;
   logic [DATA_W-1:0] rd_masked;

   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ce_n_q;
   logic              we_n_q;
   logic              oe_n_q;
   logic [LANES-1:0]  be_n_q;
   logic [DATA_W-1:0] dq_out_q;
   logic              dq_oe_q;

   sram_pwrup_wait #(.CYC(PWRUP_CYC)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_ok)
   );

   sram_phase_cnt #(.MAXV(PH_MAX)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .last     (ph_last)
   );

   sram_lane_map #(.LANES(LANES), .DATA_W(DATA_W)) u_lanes (
      .req_mask  (req_be),
      .held_mask (mask_q),
      .dq_in     (mem_dq_in),
      .be_n      (req_be_n),
      .rd_masked (rd_masked)
   );

   assign req_ready = pwr_ok && (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      ph_load = 1'b0;
      ph_val  = '0;
      if (accept && (req_be != '0)) begin
         ph_load = 1'b1;
         ph_val  = req_write ? PH_W'(WR_CYC - 1) : PH_W'(RD_CYC - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mask_q     <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         addr_q     <= '0;
         ce_n_q     <= 1'b1;
         we_n_q     <= 1'b1;
         oe_n_q     <= 1'b1;
         be_n_q     <= '1;
         dq_out_q   <= '0;
         dq_oe_q    <= 1'b0;
      end else begin
         rd_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (req_be == '0) begin
                     if (!req_write) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= '0;
                     end
                  end else begin
                     addr_q <= req_addr;
                     mask_q <= req_be;
                     ce_n_q <= 1'b0;
                     be_n_q <= req_be_n;
                     if (req_write) begin
                        we_n_q   <= 1'b0;
                        dq_out_q <= req_wdata;
                        dq_oe_q  <= 1'b1;
                        state_q  <= ST_WR;
                     end else begin
                        oe_n_q  <= 1'b0;
                        state_q <= ST_RD;
                     end
                  end
               end
            end
            ST_RD: begin
               if (ph_last) begin
                  rd_data_q  <= rd_masked;
                  rd_valid_q <= 1'b1;
                  ce_n_q     <= 1'b1;
                  oe_n_q     <= 1'b1;
                  be_n_q     <= '1;
                  state_q    <= ST_IDLE;
               end
            end
            ST_WR: begin
               if (ph_last) begin
                  we_n_q  <= 1'b1;
                  state_q <= ST_WREC;
               end
            end
            ST_WREC: begin
               ce_n_q  <= 1'b1;
               be_n_q  <= '1;
               dq_oe_q <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = ce_n_q;
   assign mem_we_n   = we_n_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_be_n   = be_n_q;
   assign mem_dq_out = dq_out_q;
   assign mem_dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_byte_ctl_chk.sv
module sram_byte_ctl_chk
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int LANES      = 2,
   parameter int CLK_PS     = 10000,
   parameter int T_PWRUP_PS = 100_000_000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   localparam int PWRUP_CYC = ps_to_cyc(T_PWRUP_PS, CLK_PS);

   int unsigned since_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst_q <= 0;
      end else if (since_rst_q < PWRUP_CYC) begin
         since_rst_q <= since_rst_q + 1;
      end
   end

   // R1
   pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q < PWRUP_CYC) |-> !req_ready);

   // R2
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

   // R3
   we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && !(&mem_be_n) && mem_oe_n));

   // R4
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_dq_out)));

   // R4
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

   // R6
   no_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R6
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mem_oe_n) |-> !mem_dq_oe);

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   // R5
   rdv_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> mem_ce_n);

endmodule

bind sram_byte_ctl sram_byte_ctl_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .LANES      (LANES),
   .CLK_PS     (CLK_PS),
   .T_PWRUP_PS (T_PWRUP_PS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_be_n   (mem_be_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_byte_ctl_tb.sv
module sram_byte_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_PS_B   = 10000;
   localparam int SWEEP      = 256;

   function automatic int cdiv(input int t, input int c);
      return (t + c - 1) / c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int PWR_E = cdiv(100_000_000, CLK_PS_B);
   localparam int RD_E  = mx(mx(cdiv(10000, CLK_PS_B), cdiv(5000, CLK_PS_B)),
                             mx(cdiv(10000, CLK_PS_B), 1));
   localparam int WR_E  = mx(mx(cdiv(7000, CLK_PS_B), cdiv(5000, CLK_PS_B)),
                             mx(cdiv(10000, CLK_PS_B) - 1, 1));

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [15:0] req_addr, req_wdata;
   logic [1:0]  req_be;
   logic        req_ready, rd_valid;
   logic [15:0] rd_data, mem_addr, mem_dq_out, mem_dq_in;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [15:0] model_mem [SWEEP];
   logic [15:0] shadow    [SWEEP];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_byte_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // RAM model: lanes not enabled read back as 8'hEE garbage.
   always_comb begin
      mem_dq_in = 16'hEEEE;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         if (!mem_be_n[0]) mem_dq_in[7:0]  = model_mem[mem_addr[7:0]][7:0];
         if (!mem_be_n[1]) mem_dq_in[15:8] = model_mem[mem_addr[7:0]][15:8];
      end
   end

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Pin monitor
   int          bus_cnt = 0;
   int          oe_run = 0, we_run = 0;
   logic        prev_we_n = 1'b1;
   logic [15:0] prev_dq = '0;
   bit          after_hold = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!mem_ce_n) bus_cnt++;
         if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[0]) model_mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) model_mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
         end
         if (mem_dq_oe && !mem_oe_n) chk(0, "R6 drive with oe low", 1, 0);
         if (!mem_oe_n) oe_run++;
         else if (oe_run > 0) begin
            chk(oe_run == RD_E, "R9 read phase length", oe_run, RD_E);
            oe_run = 0;
         end
         if (after_hold) begin
            chk(mem_ce_n && (&mem_be_n) && !mem_dq_oe, "R3 release after hold",
                {mem_ce_n, mem_be_n, mem_dq_oe}, 4'b1110);
            after_hold = 0;
         end
         if (!mem_we_n) we_run++;
         else if (!prev_we_n) begin
            chk(we_run == WR_E, "R9 write strobe length", we_run, WR_E);
            chk(!mem_ce_n && mem_dq_oe && mem_dq_out == prev_dq, "R4 hold cycle",
                {mem_ce_n, mem_dq_oe, mem_dq_out}, {2'b01, prev_dq});
            we_run = 0;
            after_hold = 1;
         end
         prev_we_n = mem_we_n;
         prev_dq   = mem_dq_out;
      end
   end

   function automatic logic [15:0] lane_mask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   function automatic logic [15:0] addr_of(input int i);
      return {8'(i) ^ 8'h3C, 8'(i)};
   endfunction

   task automatic idle_check();
      chk(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe,
          "R2 idle pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
          6'b111110);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                           input logic [1:0] m);
      int bc;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      idle_check();
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = m;
      bc = bus_cnt;
      @(negedge clk);
      req_valid = 0;
      if (m == 2'b00) begin
         chk(mem_ce_n && req_ready, "R7 zero-mask write idle",
             {mem_ce_n, req_ready}, 2'b11);
      end else begin
         chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_be_n == ~m,
             "R3 write strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n},
             {3'b001, ~m});
         chk(mem_dq_oe && mem_dq_out == d && mem_addr == a, "R4 write drive",
             mem_dq_out, d);
         chk(!req_ready, "R8 busy", req_ready, 0);
         shadow[a[7:0]] = (shadow[a[7:0]] & ~lane_mask(m)) | (d & lane_mask(m));
      end
      while (!req_ready) @(negedge clk);
      if (m == 2'b00) chk(bus_cnt == bc, "R7 zero-mask write bus", bus_cnt, bc);
   endtask

   task automatic do_read(input logic [15:0] a, input logic [1:0] m);
      int n;
      int bc;
      logic [15:0] exp;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      idle_check();
      req_valid = 1; req_write = 0; req_addr = a; req_be = m;
      bc = bus_cnt;
      @(negedge clk);
      req_valid = 0;
      if (m != 2'b00) begin
         chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_be_n == ~m &&
             mem_addr == a, "R5 read strobes",
             {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, {3'b001, ~m});
      end
      n = 0;
      while (!rd_valid && n < 32) begin
         @(negedge clk);
         n++;
      end
      exp = shadow[a[7:0]] & lane_mask(m);
      if (m == 2'b00) begin
         chk(n == 0, "R7 zero-mask read latency", n, 0);
         chk(bus_cnt == bc, "R7 zero-mask read bus", bus_cnt, bc);
         chk(rd_data == 16'h0, "R7 zero-mask read data", rd_data, 0);
      end else begin
         chk(n == RD_E, "R5 read latency", n, RD_E);
         chk(rd_data == exp, "R10 read data", rd_data, exp);
      end
      @(negedge clk);
      chk(!rd_valid, "R5 single pulse", rd_valid, 0);
   endtask

   initial begin
      for (int i = 0; i < SWEEP; i++) begin
         model_mem[i] = '0;
         shadow[i]    = '0;
      end
      rst_n = 0; req_valid = 0; req_write = 0;
      req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) @(negedge clk);
      chk(!req_ready && !rd_valid, "R2 reset outputs", {req_ready, rd_valid}, 0);
      idle_check();
      // A request held during the wait must not reach the RAM.
      req_valid = 1; req_write = 1; req_be = 2'b11; req_wdata = 16'hFFFF;
      rst_n = 1;
      begin
         int n;
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!req_ready && n < 20000);
         req_valid = 0;
         chk(n == PWR_E, "R1 power-up cycles", n, PWR_E);
         chk(bus_cnt == 0, "R1 no bus during wait", bus_cnt, 0);
      end

      for (int i = 0; i < SWEEP; i++)
         do_write(addr_of(i), 16'(i * 16'h9E37) ^ 16'h5A5A, 2'b11);
      for (int i = 0; i < SWEEP; i++)
         do_read(addr_of(i), 2'b11);

      for (int i = 0; i < SWEEP; i++)
         do_write(addr_of(i), ~(16'(i * 16'h0123) + 16'h0F0F), 2'((i % 3) + 1));
      for (int i = 0; i < SWEEP; i++)
         do_read(addr_of(i), 2'((i + 1) % 4));

      for (int i = 0; i < SWEEP; i++)
         do_write(addr_of(i), 16'hC3C3 ^ 16'(i), 2'b00);
      for (int i = 0; i < SWEEP; i++)
         do_read(addr_of(i), 2'b11);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule